// File: doc/BRIEF.md
# DMA Host Register Command Decoder

This block sits between a host I/O bus and a four-channel DMA controller. Each host access is one clock cycle with the chip select and a read or write strobe high. The block decodes the 4-bit register address into write enables for the controller's registers. Some addresses are commands: the access itself triggers them, and the data byte is ignored. On a read of a command address the returned byte has no defined meaning.

The block keeps four pieces of state.

- A byte-order flip-flop chooses which half of a 16-bit channel address or count register the next byte access reaches.
- A 2-bit pointer steps through the four stored mode bytes, which share a single read address.
- The per-channel mask bits are held here.
- A wide-transfer flag is raised only by an exact command sequence: a hardware reset or master clear, then the set-byte-order command, then the clear-byte-order command, with no other access between them.

Address map:

| Address | Write | Read |
|---|---|---|
| 0..7 | Channel register | Channel register |
| 8 | Command register enable | — |
| 9 | Request register enable | — |
| 10 | Single mask bit | Clear mode pointer |
| 11 | Mode byte | Mode readback |
| 12 | Low-first command | Low-first command |
| 13 | High-first command | High-first command |
| 14 | Master clear | Master clear |
| 15 | Unmask all | Unmask all |

For addresses 0..7, bits [2:1] give the channel and bit 0 selects count (1) or address (0). Addresses 12..15 act the same way on a read or a write.

Top module: `dma_cmd_decoder`

## Requirements
- R1: After hardware reset `mask` is 4'hF, `wide_mode` is 0, `byte_hi` is 0 and the mode pointer selects channel 0.
- R2: An access to addresses 0..7 gives `ch_sel`=addr[2:1] and `ch_cnt`=addr[0], and it asserts `ch_we` on a write only. The access toggles `byte_hi` at the end of its cycle.
- R3: An access to address 13 sets `byte_hi` to 1 and an access to address 12 clears it. Each happens on a read or a write, whatever the data.
- R4: `wide_mode` becomes 1 after a reset or master clear is followed by an access to 13 and then an access to 12. Cycles without an access may fall between these steps.
- R5: Any other access between the steps of R4, or a different order of the steps, leaves `wide_mode` at 0.
- R6: Once set, `wide_mode` stays 1 through every access except master clear. Only hardware reset and master clear return it to 0.
- R7: An access to 14 is a master clear. It pulses `clr_regs` in the same cycle, and `clr_regs` is also high during reset. Afterwards the state matches R1 and the wide-mode sequence of R4 is armed again. Stored mode bytes are kept.
- R8: An access to 15 clears all mask bits. A write to 10 sets mask bit wdata[1:0] to the value of wdata[2].
- R9: A write to 11 stores wdata[7:2] as the mode of channel wdata[1:0]. A read of 11 returns {mode of the pointed channel, 2'b11} and then advances the pointer, wrapping from 3 to 0. A read of 10 returns the pointer to channel 0.
- R10: `cmd_we` is high during a write to 8 and `req_we` is high during a write to 9.
- R11: A strobe while `cs` is low has no effect on outputs or state, and it does not count as an access for R4 or R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe; wins if `rd` is high in the same cycle |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Mode readback byte; zero for other accesses |
| ch_we | output | 1 | Write enable for a channel address or count register |
| ch_sel | output | 2 | Channel of the current channel-register access |
| ch_cnt | output | 1 | 1 = count register, 0 = address register |
| byte_hi | output | 1 | Byte-order flip-flop: 1 = high byte is next |
| cmd_we | output | 1 | Command register write enable |
| req_we | output | 1 | Request register write enable |
| clr_regs | output | 1 | Clears the controller's command, status, request and temporary registers |
| mask | output | 4 | Channel mask bits |
| wide_mode | output | 1 | 16-bit transfer mode enabled |

## Verification
The wide-mode detector is driven with five patterns, each of which isolates one rule:

- the clean three-step sequence;
- the sequence broken by a channel access;
- the sequence with the set command repeated;
- the steps in reverse order;
- the sequence with idle cycles and chip-select-low strobes inserted.

Together they separate "only accesses count" from "any cycle breaks it". The mode readback is exercised through a full pointer wrap and a mid-way pointer clear, which shows that the pointer and the stored bytes are independent. A long seeded random run over all sixteen addresses, with reads and writes mixed, compares every output against a bench model. That run catches any interaction between the byte-order flip-flop, the commands and the mask that the directed cases miss.

// File: rtl/dma_cmd_decoder.sv
module dma_cmd_decoder (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs,
  input  logic       rd,
  input  logic       wr,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       ch_we,
  output logic [1:0] ch_sel,
  output logic       ch_cnt,
  output logic       byte_hi,
  output logic       cmd_we,
  output logic       req_we,
  output logic       clr_regs,
  output logic [3:0] mask,
  output logic       wide_mode
);
  localparam logic [3:0] A_CMD    = 4'd8;
  localparam logic [3:0] A_REQ    = 4'd9;
  localparam logic [3:0] A_MASK   = 4'd10;
  localparam logic [3:0] A_MODE   = 4'd11;
  localparam logic [3:0] A_FF_LO  = 4'd12;
  localparam logic [3:0] A_FF_HI  = 4'd13;
  localparam logic [3:0] A_MCLR   = 4'd14;
  localparam logic [3:0] A_UNMASK = 4'd15;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ARMED, SQ_SET} seq_t;

  logic       wr_acc, rd_acc, any_acc;
  logic       cmd_lo, cmd_hi, cmd_mclr, cmd_unmask;
  logic       mask_wr, ptr_clr, mode_wr, mode_rd;
  logic       wipe, ff_q, wide_q;
  seq_t       seq_q;
  logic [1:0] ptr_q;
  logic [3:0] mask_q;
  logic [5:0] mode_q [4];

  assign wr_acc     = cs & wr;
  assign rd_acc     = cs & rd & ~wr;
  assign any_acc    = wr_acc | rd_acc;

  assign cmd_lo     = any_acc && addr == A_FF_LO;
  assign cmd_hi     = any_acc && addr == A_FF_HI;
  assign cmd_mclr   = any_acc && addr == A_MCLR;
  assign cmd_unmask = any_acc && addr == A_UNMASK;
  assign mask_wr    = wr_acc && addr == A_MASK;
  assign ptr_clr    = rd_acc && addr == A_MASK;
  assign mode_wr    = wr_acc && addr == A_MODE;
  assign mode_rd    = rd_acc && addr == A_MODE;
  assign wipe       = rst | cmd_mclr;

  assign ch_we      = wr_acc & ~addr[3];
  assign ch_sel     = addr[2:1];
  assign ch_cnt     = addr[0];
  assign cmd_we     = wr_acc && addr == A_CMD;
  assign req_we     = wr_acc && addr == A_REQ;
  assign clr_regs   = wipe;
  assign byte_hi    = ff_q;
  assign mask       = mask_q;
  assign wide_mode  = wide_q;
  assign rdata      = mode_rd ? {mode_q[ptr_q], 2'b11} : 8'h00;

  always_ff @(posedge clk) begin
    if (wipe)                    ff_q <= 1'b0;
    else if (cmd_hi)             ff_q <= 1'b1;
    else if (cmd_lo)             ff_q <= 1'b0;
    else if (any_acc && !addr[3]) ff_q <= ~ff_q;
  end

  always_ff @(posedge clk) begin
    if (wipe) begin
      seq_q  <= SQ_ARMED;
      wide_q <= 1'b0;
    end else if (any_acc) begin
      if (seq_q == SQ_ARMED && cmd_hi) begin
        seq_q <= SQ_SET;
      end else if (seq_q == SQ_SET && cmd_lo) begin
        seq_q  <= SQ_IDLE;
        wide_q <= 1'b1;
      end else begin
        seq_q <= SQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wipe || ptr_clr) ptr_q <= 2'd0;
    else if (mode_rd)    ptr_q <= ptr_q + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (wipe)            mask_q <= 4'hF;
    else if (cmd_unmask) mask_q <= 4'h0;
    else if (mask_wr)    mask_q[wdata[1:0]] <= wdata[2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) mode_q[i] <= 6'd0;
    end else if (mode_wr) begin
      mode_q[wdata[1:0]] <= wdata[7:2];
    end
  end

  AST_WIDE_NEEDS_SEQ: assert property (@(posedge clk) disable iff (rst)
    $rose(wide_q) |-> $past(seq_q == SQ_SET && cmd_lo));            // R4
  AST_WIDE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (wide_q && !cmd_mclr) |=> wide_q);                               // R6
  AST_MCLR_STATE: assert property (@(posedge clk) disable iff (rst)
    cmd_mclr |=> (mask_q == 4'hF && !wide_q && !ff_q && ptr_q == 2'd0)); // R7
  AST_UNMASK_ALL: assert property (@(posedge clk) disable iff (rst)
    (cmd_unmask && !cmd_mclr) |=> mask_q == 4'h0);                   // R8
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    mode_rd |=> ptr_q == $past(ptr_q) + 2'd1);                       // R9
  AST_NO_CS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cs |=> ($stable(mask_q) && $stable(ff_q) && $stable(wide_q)));  // R11
endmodule

// File: tb/dma_cmd_decoder_tb_top.sv
module dma_cmd_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       ch_we, ch_cnt, byte_hi, cmd_we, req_we, clr_regs, wide_mode;
  logic [1:0] ch_sel;
  logic [3:0] mask;

  int checks = 0;
  int errors = 0;

  int m_ff, m_wide, m_seq, m_ptr, m_mask;
  int m_mode [4];

  dma_cmd_decoder dut_i (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ch_we(ch_we), .ch_sel(ch_sel), .ch_cnt(ch_cnt),
    .byte_hi(byte_hi), .cmd_we(cmd_we), .req_we(req_we), .clr_regs(clr_regs),
    .mask(mask), .wide_mode(wide_mode)
  );

  always #10 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_rdata(int a, bit r, bit w, bit c);
    if (c && r && !w && a == 11) return (m_mode[m_ptr] << 2) | 3;
    return 0;
  endfunction

  task automatic model_wipe(bit hard);
    m_ff = 0; m_wide = 0; m_seq = 1; m_ptr = 0; m_mask = 15;
    if (hard) for (int i = 0; i < 4; i++) m_mode[i] = 0;
  endtask

  task automatic model_step(int a, bit r, bit w, bit c, int d);
    bit acc = c && (r || w);
    bit isw = c && w;
    bit isr = c && r && !w;
    if (!acc) return;
    if (a == 14) begin model_wipe(0); return; end
    if (m_seq == 1 && a == 13) m_seq = 2;
    else if (m_seq == 2 && a == 12) begin m_seq = 0; m_wide = 1; end
    else m_seq = 0;
    if (a == 13) m_ff = 1;
    else if (a == 12) m_ff = 0;
    else if (a < 8) m_ff = 1 - m_ff;
    if (isr && a == 10) m_ptr = 0;
    if (isr && a == 11) m_ptr = (m_ptr + 1) % 4;
    if (a == 15) m_mask = 0;
    if (isw && a == 10) begin
      if (d[2]) m_mask = m_mask | (1 << d[1:0]);
      else      m_mask = m_mask & ~(1 << d[1:0]);
    end
    if (isw && a == 11) m_mode[d[1:0]] = d[7:2];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cs = 1'b0; rd = 1'b0; wr = 1'b0;
    @(negedge clk);
    chk("R7 clr_regs in reset", clr_regs, 1);
    @(negedge clk);
    rst = 1'b0;
    model_wipe(1);
  endtask

  task automatic access(bit c, bit r, bit w, int a, int d, string tag);
    @(negedge clk);
    cs = c; rd = r; wr = w; addr = a[3:0]; wdata = d[7:0];
    #2;
    chk("R2 ch_we", ch_we, (c && w && a < 8) ? 1 : 0);
    if (c && w && a < 8) begin
      chk("R2 ch_sel", ch_sel, (a >> 1) & 3);
      chk("R2 ch_cnt", ch_cnt, a & 1);
    end
    chk("R10 cmd_we", cmd_we, (c && w && a == 8) ? 1 : 0);
    chk("R10 req_we", req_we, (c && w && a == 9) ? 1 : 0);
    chk("R7 clr_regs", clr_regs, (c && (r || w) && a == 14) ? 1 : 0);
    if (c && r && !w && a == 11) chk("R9 rdata", rdata, exp_rdata(a, r, w, c));
    @(posedge clk);
    model_step(a, r, w, c, d);
    #2;
    cs = 1'b0; rd = 1'b0; wr = 1'b0;
    chk({tag, " wide_mode"}, wide_mode, m_wide);
    chk("R3 byte_hi", byte_hi, m_ff);
    chk("R8 mask", mask, m_mask);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_wipe(1);
    do_reset();

    chk("R1 mask", mask, 15);
    chk("R1 wide_mode", wide_mode, 0);
    chk("R1 byte_hi", byte_hi, 0);
    access(1, 1, 0, 11, 0, "R1");              // R1: pointer at channel 0, mode 0

    // R4 clean sequence; commands on read and write with arbitrary data
    do_reset();
    access(1, 0, 1, 13, 8'h5A, "R4");
    access(1, 1, 0, 12, 8'hC3, "R4");
    chk("R4 wide after sequence", wide_mode, 1);

    // R6: wide stays through non-clear accesses
    for (int i = 0; i < 40; i++) begin
      int a = $urandom_range(0, 15);
      if (a == 14) a = 8;
      access(1, $urandom_range(0, 1), $urandom_range(0, 1), a, $urandom_range(0, 255), "R6");
    end
    chk("R6 wide sticky", wide_mode, 1);

    // R7 master clear returns to 8-bit, then re-arms
    access(1, 0, 1, 0, 0, "R7");
    access(1, 0, 1, 14, 8'hFF, "R7");
    chk("R7 wide cleared", wide_mode, 0);
    chk("R7 mask set", mask, 15);
    access(1, 0, 1, 13, 0, "R7");
    access(1, 0, 1, 12, 0, "R7");
    chk("R7 rearmed wide", wide_mode, 1);

    // R5 break with channel access
    do_reset();
    access(1, 0, 1, 13, 0, "R5");
    access(1, 1, 0, 3, 0, "R5");
    access(1, 0, 1, 12, 0, "R5");
    chk("R5 broken by access", wide_mode, 0);
    // R5 repeated set
    do_reset();
    access(1, 0, 1, 13, 0, "R5");
    access(1, 0, 1, 13, 0, "R5");
    access(1, 0, 1, 12, 0, "R5");
    chk("R5 repeated set", wide_mode, 0);
    // R5 reverse order
    do_reset();
    access(1, 0, 1, 12, 0, "R5");
    access(1, 0, 1, 13, 0, "R5");
    access(1, 0, 1, 12, 0, "R5");
    chk("R5 reverse order", wide_mode, 0);
    // R11 idle cycles and cs-low strobes do not break the sequence
    do_reset();
    idle(3);
    access(0, 0, 1, 14, 0, "R11");
    access(1, 1, 0, 13, 0, "R11");
    access(0, 1, 1, 5, 0, "R11");
    idle(2);
    access(1, 0, 1, 12, 0, "R11");
    chk("R11 gaps ignored", wide_mode, 1);

    // R2 toggling of byte order over channel accesses
    do_reset();
    for (int a = 0; a < 8; a++) access(1, a & 1, ~a & 1, a, a, "R2");
    chk("R2 byte_hi after eight", byte_hi, 0);

    // R8 mask control
    access(1, 0, 1, 15, 0, "R8");
    chk("R8 unmask all", mask, 0);
    access(1, 0, 1, 10, 8'h06, "R8");
    chk("R8 single set ch2", mask, 4'b0100);
    access(1, 0, 1, 10, 8'h02, "R8");
    chk("R8 single clear ch2", mask, 0);

    // R9 mode storage, readback wrap and pointer clear
    for (int ch = 0; ch < 4; ch++) access(1, 0, 1, 11, ((ch * 13 + 7) << 2) | ch, "R9");
    for (int k = 0; k < 6; k++) access(1, 1, 0, 11, 0, "R9");
    access(1, 1, 0, 10, 0, "R9");
    access(1, 1, 0, 11, 0, "R9");
    access(1, 0, 1, 14, 0, "R9");
    access(1, 1, 0, 11, 0, "R9");               // R9 modes kept over master clear

    // random run
    for (int i = 0; i < 2000; i++) begin
      access($urandom_range(0, 7) != 0, $urandom_range(0, 1), $urandom_range(0, 1),
             $urandom_range(0, 15), $urandom_range(0, 255), "R4");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule